// File: doc/BRIEF.md
# Decode-Stage Register Lock Controller

This block lives in the decode stage of an in-order pipeline. It keeps a scoreboard with one lock bit for each architectural register. A register is locked while an instruction that writes it is still in flight. Each cycle it looks at the decoded instruction presented by fetch: the opcode class and the rX, rY and rZ register fields. If any register that class actually reads is locked, the instruction is refused. The block then raises its registered stall output and sends a bubble toward execute in place of the refused instruction.

An instruction that is accepted travels to execute through one register stage, together with the locks it places. Port 0 carries the destination lock. Port 1 carries the status-register lock. Two release ports from later stages clear lock bits at write-back. Two conditions affect the outputs. While the downstream stall input is high, every output holds. In the cycle right after a self-stall, the input is ignored, so that the instruction being replayed upstream cannot lock anything twice.

The status register is entry NREG-1 of the scoreboard and the link register is entry NREG-2. With the default NREG of 16, these are entries 15 and 14.

Top module: `regguard_top`

## Requirements
- R1: After reset, all lock bits are clear. stall_out, out_valid, lock0_en and lock1_en are 0, and every index and field output is 0.
- R2: Opcode class encoding and the operands each class reads:
  - 0 = no-op, reads nothing.
  - 1 = register ALU, reads rX and rY.
  - 2 = immediate ALU, reads rX.
  - 3 = load, reads rY.
  - 4 = store, reads rX and rY.
  - 5 = jump, reads rX.
  - 6 = conditional branch, reads rX and the status register.
  - 7 = three-operand ALU, reads rY and rZ.

  In an evaluated cycle, a valid instruction that reads a locked register sets stall_out at the next clock edge.
- R3: A field that the class does not read never causes a stall, even when the register it names is locked.
- R4: A refused instruction produces a bubble: out_valid is 0, out_cls/out_rx/out_ry/out_rz are 0, and no lock is requested or set.
- R5: While stall_in is high, the clock edge changes none of the outputs and creates no lock. The release ports still clear lock bits.
- R6: In a cycle where stall_out is already high and stall_in is low, the input is ignored. The next edge gives a bubble with no lock and stall_out 0.
- R7: An accepted class 1, 2, 3 or 7 instruction locks rX. The edge that accepts it shows lock0_en=1 and lock0_idx=rX.
- R8: An accepted jump (class 5) locks the link register (index NREG-2) through port 0.
- R9: An accepted class 1, 2 or 7 instruction locks the status register (index NREG-1) through port 1. A later branch that reads the status register while it is locked stalls.
- R10: A release clears its lock bit. When a release and a new lock hit the same register in the same cycle, the register stays locked.
- R11: An accepted instruction passes in_cls, in_rx, in_ry and in_rz unchanged to the out_* fields with out_valid=1. An index output whose enable is 0 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Decoded instruction present |
| in_cls | input | 3 | Opcode class (encoding in R2) |
| in_rx | input | 4 | rX field |
| in_ry | input | 4 | rY field |
| in_rz | input | 4 | rZ field |
| stall_in | input | 1 | Downstream stall, holds all outputs |
| rel0_en | input | 1 | Release port 0 enable |
| rel0_idx | input | 4 | Release port 0 register |
| rel1_en | input | 1 | Release port 1 enable |
| rel1_idx | input | 4 | Release port 1 register |
| stall_out | output | 1 | Registered stall toward the earlier stages |
| out_valid | output | 1 | Instruction (1) or bubble (0) toward execute |
| out_cls | output | 3 | Forwarded class |
| out_rx | output | 4 | Forwarded rX |
| out_ry | output | 4 | Forwarded rY |
| out_rz | output | 4 | Forwarded rZ |
| lock0_en | output | 1 | Destination or link lock placed |
| lock0_idx | output | 4 | Register locked by port 0 |
| lock1_en | output | 1 | Status-register lock placed |
| lock1_idx | output | 4 | Register locked by port 1 |

## Verification
The hardest situation to reach from the ports is the one where a release and a new lock hit the same register in one cycle. A close second is a hazard that clears during the ignored cycle after a self-stall. Both need the right lock state to be built up first.

Directed sequences set these cases up explicitly. They lock a register, pair its release with a fresh lock, and replay a refused instruction across the ignored cycle. Random traffic with a fixed seed then follows. It draws register indices from the whole file and uses occasional releases and downstream stalls, and the upstream model holds each instruction while a stall is pending. A bench scoreboard model predicts every output on every edge.

// File: rtl/regguard_pkg.sv
package regguard_pkg;

  typedef enum logic [2:0] {
    CL_NOP   = 3'd0,
    CL_ALU   = 3'd1,
    CL_ALUI  = 3'd2,
    CL_LOAD  = 3'd3,
    CL_STORE = 3'd4,
    CL_JUMP  = 3'd5,
    CL_BRC   = 3'd6,
    CL_ALU3  = 3'd7
  } op_class_e;

  typedef struct packed {
    logic rx;
    logic ry;
    logic rz;
    logic sr;
  } rd_use_t;

  typedef struct packed {
    logic dst;
    logic link;
    logic sr;
  } wr_use_t;

  function automatic rd_use_t class_reads(op_class_e c);
    rd_use_t u;
    u = '0;
    unique case (c)
      CL_ALU:   begin u.rx = 1'b1; u.ry = 1'b1; end
      CL_ALUI:  u.rx = 1'b1;
      CL_LOAD:  u.ry = 1'b1;
      CL_STORE: begin u.rx = 1'b1; u.ry = 1'b1; end
      CL_JUMP:  u.rx = 1'b1;
      CL_BRC:   begin u.rx = 1'b1; u.sr = 1'b1; end
      CL_ALU3:  begin u.ry = 1'b1; u.rz = 1'b1; end
      default:  u = '0;
    endcase
    return u;
  endfunction

  function automatic wr_use_t class_writes(op_class_e c);
    wr_use_t w;
    w.dst  = (c == CL_ALU) || (c == CL_ALUI) || (c == CL_LOAD) || (c == CL_ALU3);
    w.link = (c == CL_JUMP);
    w.sr   = (c == CL_ALU) || (c == CL_ALUI) || (c == CL_ALU3);
    return w;
  endfunction

endpackage

// File: rtl/regguard_decode.sv
module regguard_decode
  import regguard_pkg::*;
#(
  parameter int NREG = 16,
  localparam int IW = $clog2(NREG),
  localparam int SR_IDX = NREG - 1,
  localparam int LR_IDX = NREG - 2
) (
  input  logic [2:0]      cls,
  input  logic [IW-1:0]   rx,
  input  logic [IW-1:0]   ry,
  input  logic [IW-1:0]   rz,
  input  logic [NREG-1:0] lockv,
  output logic            hazard,
  output logic            dst_en,
  output logic [IW-1:0]   dst_idx,
  output logic            sr_en
);

  rd_use_t use_r;
  wr_use_t use_w;

  always_comb begin
    use_r   = class_reads(op_class_e'(cls));
    use_w   = class_writes(op_class_e'(cls));
    hazard  = (use_r.rx && lockv[rx]) ||
              (use_r.ry && lockv[ry]) ||
              (use_r.rz && lockv[rz]) ||
              (use_r.sr && lockv[SR_IDX]);
    dst_en  = use_w.dst || use_w.link;
    dst_idx = use_w.link ? IW'(LR_IDX) : rx;
    sr_en   = use_w.sr;
  end

endmodule

// File: rtl/regguard_scoreboard.sv
module regguard_scoreboard #(
  parameter int NREG = 16,
  localparam int IW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set0_en,
  input  logic [IW-1:0]   set0_idx,
  input  logic            set1_en,
  input  logic [IW-1:0]   set1_idx,
  input  logic            clr0_en,
  input  logic [IW-1:0]   clr0_idx,
  input  logic            clr1_en,
  input  logic [IW-1:0]   clr1_idx,
  output logic [NREG-1:0] lockv
);

  logic [NREG-1:0] hit_set;
  logic [NREG-1:0] hit_clr;

  for (genvar i = 0; i < NREG; i++) begin : g_bit
    assign hit_set[i] = (set0_en && set0_idx == IW'(i)) || (set1_en && set1_idx == IW'(i));
    assign hit_clr[i] = (clr0_en && clr0_idx == IW'(i)) || (clr1_en && clr1_idx == IW'(i));
  end

  // a new lock outranks a release on the same entry
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lockv <= '0;
    else        lockv <= hit_set | (lockv & ~hit_clr);
  end

  assert_lock_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    set0_en |=> lockv[$past(set0_idx)]);

  assert_release_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr0_en && !(set0_en && set0_idx == clr0_idx) && !(set1_en && set1_idx == clr0_idx))
    |=> !lockv[$past(clr0_idx)]);

endmodule

// File: rtl/regguard_top.sv
module regguard_top
  import regguard_pkg::*;
#(
  parameter int NREG = 16,
  localparam int IW = $clog2(NREG),
  localparam int SR_IDX = NREG - 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [2:0]    in_cls,
  input  logic [IW-1:0] in_rx,
  input  logic [IW-1:0] in_ry,
  input  logic [IW-1:0] in_rz,
  input  logic          stall_in,
  input  logic          rel0_en,
  input  logic [IW-1:0] rel0_idx,
  input  logic          rel1_en,
  input  logic [IW-1:0] rel1_idx,
  output logic          stall_out,
  output logic          out_valid,
  output logic [2:0]    out_cls,
  output logic [IW-1:0] out_rx,
  output logic [IW-1:0] out_ry,
  output logic [IW-1:0] out_rz,
  output logic          lock0_en,
  output logic [IW-1:0] lock0_idx,
  output logic          lock1_en,
  output logic [IW-1:0] lock1_idx
);

  logic [NREG-1:0] lockv;
  logic            raw_hz;
  logic            dst_en;
  logic [IW-1:0]   dst_idx;
  logic            sr_en;

  // named events for the assertions
  logic eval_cyc;
  logic hz_take;
  logic accept;
  logic set0_en;
  logic set1_en;

  regguard_decode #(.NREG(NREG)) u_dec (
    .cls     (in_cls),
    .rx      (in_rx),
    .ry      (in_ry),
    .rz      (in_rz),
    .lockv   (lockv),
    .hazard  (raw_hz),
    .dst_en  (dst_en),
    .dst_idx (dst_idx),
    .sr_en   (sr_en)
  );

  // the cycle after a self-stall is ignored: upstream is replaying
  assign eval_cyc = !stall_in && !stall_out;
  assign hz_take  = eval_cyc && in_valid && raw_hz;
  assign accept   = eval_cyc && in_valid && !raw_hz;
  assign set0_en  = accept && dst_en;
  assign set1_en  = accept && sr_en;

  regguard_scoreboard #(.NREG(NREG)) u_sb (
    .clk      (clk),
    .rst_n    (rst_n),
    .set0_en  (set0_en),
    .set0_idx (dst_idx),
    .set1_en  (set1_en),
    .set1_idx (IW'(SR_IDX)),
    .clr0_en  (rel0_en),
    .clr0_idx (rel0_idx),
    .clr1_en  (rel1_en),
    .clr1_idx (rel1_idx),
    .lockv    (lockv)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stall_out <= 1'b0;
      out_valid <= 1'b0;
      out_cls   <= '0;
      out_rx    <= '0;
      out_ry    <= '0;
      out_rz    <= '0;
      lock0_en  <= 1'b0;
      lock0_idx <= '0;
      lock1_en  <= 1'b0;
      lock1_idx <= '0;
    end else if (!stall_in) begin
      stall_out <= hz_take;
      if (accept) begin
        out_valid <= 1'b1;
        out_cls   <= in_cls;
        out_rx    <= in_rx;
        out_ry    <= in_ry;
        out_rz    <= in_rz;
        lock0_en  <= dst_en;
        lock0_idx <= dst_en ? dst_idx : '0;
        lock1_en  <= sr_en;
        lock1_idx <= sr_en ? IW'(SR_IDX) : '0;
      end else begin
        out_valid <= 1'b0;
        out_cls   <= '0;
        out_rx    <= '0;
        out_ry    <= '0;
        out_rz    <= '0;
        lock0_en  <= 1'b0;
        lock0_idx <= '0;
        lock1_en  <= 1'b0;
        lock1_idx <= '0;
      end
    end
  end

  assert_hazard_stalls_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hz_take |=> stall_out && !out_valid);

  assert_bubble_R4: assert property (@(posedge clk) disable iff (!rst_n)
    stall_out |-> !out_valid && !lock0_en && !lock1_en && out_cls == '0);

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    stall_in |=> $stable(stall_out) && $stable(out_valid) && $stable(out_rx) &&
                 $stable(lock0_en) && $stable(lock1_en) && $stable(lock0_idx));

  assert_ignored_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_out && !stall_in) |=> !stall_out && !out_valid && !lock0_en && !lock1_en);

  assert_dst_lock_R7: assert property (@(posedge clk) disable iff (!rst_n)
    set0_en |=> lock0_en && out_valid && lockv[lock0_idx]);

  assert_sr_port_R9: assert property (@(posedge clk) disable iff (!rst_n)
    lock1_en |-> lock1_idx == IW'(SR_IDX) && out_valid);

endmodule

// File: tb/sim_regguard_top.sv
module sim_regguard_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [2:0] in_cls = '0;
  logic [3:0] in_rx = '0, in_ry = '0, in_rz = '0;
  logic       stall_in = 1'b0;
  logic       rel0_en = 1'b0, rel1_en = 1'b0;
  logic [3:0] rel0_idx = '0, rel1_idx = '0;
  logic       stall_out, out_valid, lock0_en, lock1_en;
  logic [2:0] out_cls;
  logic [3:0] out_rx, out_ry, out_rz, lock0_idx, lock1_idx;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  regguard_top u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_cls(in_cls),
    .in_rx(in_rx), .in_ry(in_ry), .in_rz(in_rz), .stall_in(stall_in),
    .rel0_en(rel0_en), .rel0_idx(rel0_idx), .rel1_en(rel1_en), .rel1_idx(rel1_idx),
    .stall_out(stall_out), .out_valid(out_valid), .out_cls(out_cls),
    .out_rx(out_rx), .out_ry(out_ry), .out_rz(out_rz),
    .lock0_en(lock0_en), .lock0_idx(lock0_idx), .lock1_en(lock1_en), .lock1_idx(lock1_idx)
  );

  // bench model state
  logic [15:0] m_lock;
  logic        m_stall, m_ov, m_l0e, m_l1e;
  logic [2:0]  m_cls;
  logic [3:0]  m_rx, m_ry, m_rz, m_l0i, m_l1i;

  // {rX, rY, rZ, status} read mask per class, as listed in R2
  function automatic logic [3:0] rd_mask(input logic [2:0] c);
    logic [3:0] tbl [8];
    tbl = '{4'b0000, 4'b1100, 4'b1000, 4'b0100, 4'b1100, 4'b1000, 4'b1001, 4'b0110};
    return tbl[c];
  endfunction

  function automatic logic writes_rx(input logic [2:0] c);
    return c == 3'd1 || c == 3'd2 || c == 3'd3 || c == 3'd7;
  endfunction

  function automatic logic writes_sr(input logic [2:0] c);
    return c == 3'd1 || c == 3'd2 || c == 3'd7;
  endfunction

  function automatic logic blocked(input logic [2:0] c, input logic [3:0] x, y, z,
                                   input logic [15:0] lk);
    logic [3:0] m;
    m = rd_mask(c);
    return (m[3] & lk[x]) | (m[2] & lk[y]) | (m[1] & lk[z]) | (m[0] & lk[15]);
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    chk(tag, "stall_out (R2)", int'(stall_out), int'(m_stall));
    chk(tag, "out_valid (R4)", int'(out_valid), int'(m_ov));
    chk(tag, "out_cls (R11)", int'(out_cls), int'(m_cls));
    chk(tag, "out_rx (R11)", int'(out_rx), int'(m_rx));
    chk(tag, "out_ry (R11)", int'(out_ry), int'(m_ry));
    chk(tag, "out_rz (R11)", int'(out_rz), int'(m_rz));
    chk(tag, "lock0_en (R7)", int'(lock0_en), int'(m_l0e));
    chk(tag, "lock0_idx (R8)", int'(lock0_idx), int'(m_l0i));
    chk(tag, "lock1_en (R9)", int'(lock1_en), int'(m_l1e));
    chk(tag, "lock1_idx (R9)", int'(lock1_idx), int'(m_l1i));
  endtask

  // called just after a falling edge: drive, predict, check after the rising edge
  task automatic step(input string tag, input logic v, input logic [2:0] c,
                      input logic [3:0] x, y, z, input logic si,
                      input logic e0, input logic [3:0] i0,
                      input logic e1, input logic [3:0] i1);
    logic ev, hz, acc;
    logic [15:0] setm, clrm;
    in_valid = v; in_cls = c; in_rx = x; in_ry = y; in_rz = z; stall_in = si;
    rel0_en = e0; rel0_idx = i0; rel1_en = e1; rel1_idx = i1;
    ev  = !si && !m_stall;
    hz  = ev && v && blocked(c, x, y, z, m_lock);
    acc = ev && v && !hz;
    setm = '0;
    clrm = '0;
    if (acc && writes_rx(c)) setm[x] = 1'b1;
    if (acc && c == 3'd5)    setm[14] = 1'b1;
    if (acc && writes_sr(c)) setm[15] = 1'b1;
    if (e0) clrm[i0] = 1'b1;
    if (e1) clrm[i1] = 1'b1;
    m_lock = setm | (m_lock & ~clrm);
    if (!si) begin
      m_stall = hz;
      m_ov  = acc;
      m_cls = acc ? c : 3'd0;
      m_rx  = acc ? x : 4'd0;
      m_ry  = acc ? y : 4'd0;
      m_rz  = acc ? z : 4'd0;
      m_l0e = acc && (writes_rx(c) || c == 3'd5);
      m_l0i = !m_l0e ? 4'd0 : (c == 3'd5 ? 4'd14 : x);
      m_l1e = acc && writes_sr(c);
      m_l1i = m_l1e ? 4'd15 : 4'd0;
    end
    @(posedge clk);
    #2;
    compare_all(tag);
    @(negedge clk);
  endtask

  task automatic idle(input string tag);
    step(tag, 1'b0, 3'd0, 4'd0, 4'd0, 4'd0, 1'b0, 1'b0, 4'd0, 1'b0, 4'd0);
  endtask

  task automatic free_all();
    for (int k = 0; k < 8; k++)
      step("R10 free", 1'b0, 3'd0, 4'd0, 4'd0, 4'd0, 1'b0,
           1'b1, 4'(2 * k), 1'b1, 4'(2 * k + 1));
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    logic       v, si;
    logic [2:0] c;
    logic [3:0] x, y, z;
    seed = $urandom(32'd20240611);
    m_lock = '0; m_stall = 0; m_ov = 0; m_cls = '0; m_rx = '0; m_ry = '0; m_rz = '0;
    m_l0e = 0; m_l0i = '0; m_l1e = 0; m_l1i = '0;
    repeat (3) @(negedge clk);
    compare_all("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
    compare_all("R1 after release");

    // R7 destination lock, then R2 stall, R6 ignored cycle, re-stall
    step("R7 alu locks r3", 1, 3'd1, 4'd3, 4'd4, 4'd0, 0, 0, 0, 0, 0);
    step("R2 store reads r3", 1, 3'd4, 4'd3, 4'd5, 4'd0, 0, 0, 0, 0, 0);
    step("R6 ignored cycle", 1, 3'd4, 4'd3, 4'd5, 4'd0, 0, 0, 0, 0, 0);
    step("R4 bubble on re-stall", 1, 3'd4, 4'd3, 4'd5, 4'd0, 0, 1, 4'd3, 0, 0);
    step("R6 ignored after release", 1, 3'd4, 4'd3, 4'd5, 4'd0, 0, 0, 0, 0, 0);
    step("R11 store accepted", 1, 3'd4, 4'd3, 4'd5, 4'd0, 0, 0, 0, 0, 0);
    // R3 unread fields: r3 locked again by alu, no-op and load ignore rX/rZ
    step("R7 alu relock r3", 1, 3'd2, 4'd3, 4'd0, 4'd0, 0, 0, 0, 0, 0);
    step("R3 nop names r3", 1, 3'd0, 4'd3, 4'd3, 4'd3, 0, 0, 0, 0, 0);
    step("R3 load rz=r3 unread", 1, 3'd3, 4'd6, 4'd7, 4'd3, 0, 0, 0, 0, 0);
    free_all();
    // R8 jump locks link, load through link stalls
    step("R8 jump", 1, 3'd5, 4'd1, 4'd0, 4'd0, 0, 0, 0, 0, 0);
    step("R8 load reads link", 1, 3'd3, 4'd2, 4'd14, 4'd0, 0, 0, 0, 0, 0);
    idle("R6 ignored");
    free_all();
    // R9 status lock and branch stall
    step("R9 alu3 locks status", 1, 3'd7, 4'd8, 4'd1, 4'd2, 0, 0, 0, 0, 0);
    step("R9 branch stalls", 1, 3'd6, 4'd0, 4'd0, 4'd0, 0, 0, 0, 0, 0);
    free_all();
    // R10 release and new lock on the same register in one cycle
    step("R10 lock r6 with release r6", 1, 3'd1, 4'd6, 4'd0, 4'd0, 0, 1, 4'd6, 0, 0);
    step("R10 r6 still locked", 1, 3'd4, 4'd6, 4'd0, 4'd0, 0, 0, 0, 0, 0);
    free_all();
    // R5 downstream stall holds outputs, release still applies
    step("R5 accept alu", 1, 3'd1, 4'd9, 4'd10, 4'd0, 0, 0, 0, 0, 0);
    step("R5 hold a", 1, 3'd2, 4'd11, 4'd0, 4'd0, 1, 1, 4'd9, 0, 0);
    step("R5 hold b", 1, 3'd5, 4'd12, 4'd0, 4'd0, 1, 0, 0, 0, 0);
    step("R5 after hold", 1, 3'd4, 4'd9, 4'd10, 4'd0, 0, 0, 0, 0, 0);
    free_all();

    // random traffic; upstream holds its instruction while a stall is pending
    v = 0; c = '0; x = '0; y = '0; z = '0;
    for (int n = 0; n < 3000; n++) begin
      logic e0, e1;
      if (!stall_out && !stall_in) begin
        v = ($urandom % 8) != 0;
        c = 3'($urandom);
        x = 4'($urandom);
        y = 4'($urandom);
        z = 4'($urandom);
      end
      si = ($urandom % 7) == 0;
      e0 = ($urandom % 3) == 0;
      e1 = ($urandom % 4) == 0;
      step("R2 random", v, c, x, y, z, si, e0, 4'($urandom), e1, 4'($urandom));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule